// File: doc/BRIEF.md
# Bitmap Scanline Pixel Fetcher

This block produces one visible line of 240 pixels from a frame held in video memory, for the two bitmap display formats. A start strobe asks for a line. On that strobe the block takes in the line number and the format field and page bit of the display control word. It then walks x from 0 to 239 and issues one read per pixel to a synchronous video memory port. The result comes out as a stream of colored pixels, each with a valid flag and its x and y coordinates, and a done pulse marks the last pixel.

In direct-color format each pixel is a 15-bit RGB word stored as 16 bits. In indexed format each pixel is one byte taken from one of two frame pages, and that byte selects an entry in palette memory. Both memories answer one cycle after the address is presented, so the fetch is a short pipeline. Any other format value gives a line of zero-color pixels with the same timing. That keeps the line timing of the surrounding display engine the same for every format.

Top module: `bitmap_line_fetch`

## Requirements
- R1: While reset (rst_n low, synchronous) is applied, and after it until the next accepted start, pix_valid, line_done, vram_rd and pal_rd are all low.
- R2: On an accepted start the block captures ctrl_word[2:0] as the format, ctrl_word[4] as the page select and line_num as the line. Changes on these inputs during the line have no effect on that line.
- R3: An accepted start sampled at clock edge E gives exactly 240 pixels on the 240 consecutive cycles that begin after edge E+3. Pixel x (x ascending 0 to 239) appears after edge E+3+x, and pix_y equals the captured line.
- R4: Format 3 (direct color): pix_color is the 16-bit video word at byte offset 2*(line*240 + x).
- R5: Format 4 (indexed): the pixel byte is at byte offset P + line*240 + x, where P is 0 when the page bit is 0 and 0xA000 when it is 1. The video port returns the 16-bit word at the even address below the given offset. An even offset selects bits 7:0 and an odd offset selects bits 15:8.
- R6: In format 4, pix_color is the palette word at palette byte offset 2*i, where i is the pixel byte (palette bank 0). A palette read is issued only in the cycle right after a video read.
- R7: Any format other than 3 or 4 gives 240 pixels of color 0 with the R3 timing and issues no video or palette reads.
- R8: line_done is a single-cycle pulse that is high in the same cycle as pixel 239 and in no other cycle.
- R9: A start that arrives while a line's pixels are still being fetched (from the accepted start until the read for pixel 239) is ignored. No extra pixels result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to fetch one line |
| line_num | input | 8 | Line to fetch, 0 to 159 |
| ctrl_word | input | 16 | Display control word (format in 2:0, page in 4) |
| vram_addr | output | 17 | Video memory byte offset |
| vram_rd | output | 1 | Video memory read enable |
| vram_data | input | 16 | Video memory word, one cycle after the read |
| pal_addr | output | 9 | Palette memory byte offset |
| pal_rd | output | 1 | Palette memory read enable |
| pal_data | input | 16 | Palette word, one cycle after the read |
| pix_valid | output | 1 | Pixel output is valid |
| pix_x | output | 8 | Pixel column |
| pix_y | output | 8 | Pixel line |
| pix_color | output | 16 | Pixel color |
| line_done | output | 1 | Pulse with the last pixel of the line |

## Verification
A line accepted at edge E delivers pixel x after edge E+3+x, and line_done comes with pixel 239 after edge E+242. The bench drives inputs and samples outputs on falling edges. It counts the falling edges since the one on which start was raised, so pixel x is due at count 4+x and done at count 243. Every pixel is compared against that expected count, its coordinates and a color computed from the memory contents that the bench itself generates. The tests that change inputs mid-line and restart mid-line check that a line still holds exactly 240 pixels, and they keep sampling past count 243 so that any stray pixels are caught.

// File: rtl/bmf_pkg.sv
// Shared types and helpers for the bitmap scanline pixel fetcher.
// Assumes the display control word carries the format in bits 2:0 and
// the page select in bit 4.
package bmf_pkg;

    // Pixel encoding chosen for a line
    typedef enum logic [1:0] {
        FMT_NONE    = 2'd0,
        FMT_DIRECT  = 2'd1,
        FMT_INDEXED = 2'd2
    } fmt_e;

    localparam logic [2:0] CODE_DIRECT  = 3'd3;
    localparam logic [2:0] CODE_INDEXED = 3'd4;
    localparam int         CTRL_FMT_LSB = 0;
    localparam int         CTRL_PAGE_BIT = 4;

    // Map the 3-bit format field onto the internal encoding
    function automatic fmt_e decode_fmt(input logic [2:0] code);
        if (code == CODE_DIRECT) begin
            return FMT_DIRECT;
        end else if (code == CODE_INDEXED) begin
            return FMT_INDEXED;
        end
        return FMT_NONE;
    endfunction

endpackage

// File: rtl/bmf_seq.sv
// Line sequencer: accepts a start strobe, latches format, page and line,
// and steps the pixel column from 0 to LINE_W-1, one column per cycle.
// Assumes a start during an active walk is to be ignored.
module bmf_seq
    import bmf_pkg::*;
#(
    parameter int LINE_W = 240,
    parameter int XW     = 8,
    parameter int YW     = 8,
    parameter int CW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [YW-1:0] line_in,
    input  logic [CW-1:0] ctrl_in,
    output logic          run,
    output logic [XW-1:0] col,
    output logic [YW-1:0] row,
    output fmt_e          fmt,
    output logic          page,
    output logic          last
);
    localparam logic [XW-1:0] LAST_COL = XW'(LINE_W - 1);

    logic accept;
    assign accept = start && !run;

    // Latch line parameters on an accepted start and advance the column
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            col  <= '0;
            row  <= '0;
            fmt  <= FMT_NONE;
            page <= 1'b0;
        end else if (accept) begin
            run  <= 1'b1;
            col  <= '0;
            row  <= line_in;
            fmt  <= decode_fmt(ctrl_in[CTRL_FMT_LSB +: 3]);
            page <= ctrl_in[CTRL_PAGE_BIT];
        end else if (run) begin
            if (col == LAST_COL) begin
                run <= 1'b0;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // Flag the final column of the walk
    always_comb begin
        last = run && (col == LAST_COL);
    end

endmodule

// File: rtl/bmf_addr.sv
// Address generator: turns column, row, format and page into a video
// memory byte offset and read enable. Purely combinational; assumes
// row < number of visible lines so the offset fits VA_W bits.
module bmf_addr
    import bmf_pkg::*;
#(
    parameter int LINE_W    = 240,
    parameter int XW        = 8,
    parameter int YW        = 8,
    parameter int VA_W      = 17,
    parameter int PAGE1_OFS = 'hA000
) (
    input  logic            run,
    input  logic [XW-1:0]   col,
    input  logic [YW-1:0]   row,
    input  fmt_e            fmt,
    input  logic            page,
    output logic [VA_W-1:0] addr,
    output logic            rd
);
    localparam logic [VA_W-1:0] LINE_STRIDE = VA_W'(LINE_W);
    localparam logic [VA_W-1:0] PAGE1_BASE  = VA_W'(PAGE1_OFS);

    logic [VA_W-1:0] lin;
    logic [VA_W-1:0] page_base;

    // Linear pixel index within a frame
    always_comb begin
        lin = VA_W'(row) * LINE_STRIDE + VA_W'(col);
    end

    // Page base for the indexed encoding
    always_comb begin
        page_base = page ? PAGE1_BASE : '0;
    end

    // Byte offset per encoding and read enable
    always_comb begin
        unique case (fmt)
            FMT_DIRECT:  addr = {lin[VA_W-2:0], 1'b0};
            FMT_INDEXED: addr = page_base + lin;
            default:     addr = '0;
        endcase
        rd = run && (fmt != FMT_NONE);
    end

endmodule

// File: rtl/bmf_color.sv
// Color pipeline: stage 1 receives the video word and issues the palette
// lookup, stage 2 receives the palette word, and the output stage
// registers the final pixel. Assumes both memories return data one cycle
// after the read enable.
module bmf_color
    import bmf_pkg::*;
#(
    parameter int XW       = 8,
    parameter int YW       = 8,
    parameter int PA_W     = 9,
    parameter int PIX_W    = 16,
    parameter int PAL_BANK = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [XW-1:0]    in_col,
    input  logic [YW-1:0]    in_row,
    input  fmt_e             in_fmt,
    input  logic             in_hi,
    input  logic             in_last,
    input  logic [PIX_W-1:0] vram_data,
    output logic [PA_W-1:0]  pal_addr,
    output logic             pal_rd,
    input  logic [PIX_W-1:0] pal_data,
    output logic             pix_valid,
    output logic [XW-1:0]    pix_x,
    output logic [YW-1:0]    pix_y,
    output logic [PIX_W-1:0] pix_color,
    output logic             line_done
);
    localparam int              IDX_W     = PA_W - 1;
    localparam logic [PA_W-1:0] BANK_BASE = PA_W'(PAL_BANK * 32);

    // stage 1 state
    logic             s1_v;
    logic [XW-1:0]    s1_x;
    logic [YW-1:0]    s1_y;
    fmt_e             s1_fmt;
    logic             s1_hi;
    logic             s1_last;
    // stage 2 state
    logic             s2_v;
    logic [XW-1:0]    s2_x;
    logic [YW-1:0]    s2_y;
    fmt_e             s2_fmt;
    logic             s2_last;
    logic [PIX_W-1:0] s2_word;

    logic [IDX_W-1:0] idx;
    logic [PIX_W-1:0] color_sel;

    // Stage 1: track the read issued last cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_x    <= '0;
            s1_y    <= '0;
            s1_fmt  <= FMT_NONE;
            s1_hi   <= 1'b0;
            s1_last <= 1'b0;
        end else begin
            s1_v    <= in_valid;
            s1_x    <= in_col;
            s1_y    <= in_row;
            s1_fmt  <= in_fmt;
            s1_hi   <= in_hi;
            s1_last <= in_last;
        end
    end

    // Pick the addressed byte lane of the returned video word
    always_comb begin
        idx = s1_hi ? vram_data[PIX_W-1 -: IDX_W] : vram_data[IDX_W-1:0];
    end

    // Palette lookup address and enable
    always_comb begin
        pal_addr = BANK_BASE + {idx, 1'b0};
        pal_rd   = s1_v && (s1_fmt == FMT_INDEXED);
    end

    // Stage 2: capture direct word and wait for palette data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_x    <= '0;
            s2_y    <= '0;
            s2_fmt  <= FMT_NONE;
            s2_last <= 1'b0;
            s2_word <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_x    <= s1_x;
            s2_y    <= s1_y;
            s2_fmt  <= s1_fmt;
            s2_last <= s1_last;
            s2_word <= (s1_v && s1_fmt == FMT_DIRECT) ? vram_data : '0;
        end
    end

    // Final color by encoding
    always_comb begin
        unique case (s2_fmt)
            FMT_DIRECT:  color_sel = s2_word;
            FMT_INDEXED: color_sel = pal_data;
            default:     color_sel = '0;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_x     <= '0;
            pix_y     <= '0;
            pix_color <= '0;
            line_done <= 1'b0;
        end else begin
            pix_valid <= s2_v;
            pix_x     <= s2_x;
            pix_y     <= s2_y;
            pix_color <= s2_v ? color_sel : '0;
            line_done <= s2_v && s2_last;
        end
    end

endmodule

// File: rtl/bitmap_line_fetch.sv
// Top of the bitmap scanline pixel fetcher. Fetches one line of LINE_W
// pixels in direct-color or indexed format and streams them out with
// coordinates. Assumes synchronous memories with one cycle read latency.
module bitmap_line_fetch
    import bmf_pkg::*;
#(
    parameter int LINE_W    = 240,
    parameter int NUM_LINES = 160,
    parameter int CW        = 16,
    parameter int VA_W      = 17,
    parameter int PA_W      = 9,
    parameter int PIX_W     = 16,
    parameter int PAGE1_OFS = 'hA000,
    parameter int PAL_BANK  = 0,
    localparam int XW       = $clog2(LINE_W),
    localparam int YW       = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [YW-1:0]    line_num,
    input  logic [CW-1:0]    ctrl_word,
    output logic [VA_W-1:0]  vram_addr,
    output logic             vram_rd,
    input  logic [PIX_W-1:0] vram_data,
    output logic [PA_W-1:0]  pal_addr,
    output logic             pal_rd,
    input  logic [PIX_W-1:0] pal_data,
    output logic             pix_valid,
    output logic [XW-1:0]    pix_x,
    output logic [YW-1:0]    pix_y,
    output logic [PIX_W-1:0] pix_color,
    output logic             line_done
);
    logic          run;
    logic [XW-1:0] col;
    logic [YW-1:0] row;
    fmt_e          fmt;
    logic          page;
    logic          last;

    bmf_seq #(
        .LINE_W (LINE_W),
        .XW     (XW),
        .YW     (YW),
        .CW     (CW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .line_in (line_num),
        .ctrl_in (ctrl_word),
        .run     (run),
        .col     (col),
        .row     (row),
        .fmt     (fmt),
        .page    (page),
        .last    (last)
    );

    bmf_addr #(
        .LINE_W    (LINE_W),
        .XW        (XW),
        .YW        (YW),
        .VA_W      (VA_W),
        .PAGE1_OFS (PAGE1_OFS)
    ) u_addr (
        .run  (run),
        .col  (col),
        .row  (row),
        .fmt  (fmt),
        .page (page),
        .addr (vram_addr),
        .rd   (vram_rd)
    );

    bmf_color #(
        .XW       (XW),
        .YW       (YW),
        .PA_W     (PA_W),
        .PIX_W    (PIX_W),
        .PAL_BANK (PAL_BANK)
    ) u_color (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (run),
        .in_col    (col),
        .in_row    (row),
        .in_fmt    (fmt),
        .in_hi     (vram_addr[0]),
        .in_last   (last),
        .vram_data (vram_data),
        .pal_addr  (pal_addr),
        .pal_rd    (pal_rd),
        .pal_data  (pal_data),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_color (pix_color),
        .line_done (line_done)
    );

endmodule

// File: rtl/bmf_checker.sv
// Property checker for the bitmap scanline pixel fetcher, bound to the
// top module. Observes ports only.
module bmf_checker #(
    parameter int XW     = 8,
    parameter int YW     = 8,
    parameter int LINE_W = 240
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vram_rd,
    input logic          pal_rd,
    input logic          pix_valid,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] pix_y,
    input logic          line_done
);
    localparam logic [XW-1:0] LAST_X = XW'(LINE_W - 1);

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (pix_valid && pix_x == LAST_X)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done); // R8

    AST_X_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_x != LAST_X) |=> (pix_valid && pix_x == $past(pix_x) + 1'b1)); // R3

    AST_Y_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_x != LAST_X) |=> $stable(pix_y)); // R2

    AST_PAL_AFTER_VRAM: assert property (@(posedge clk) disable iff (!rst_n)
        pal_rd |-> $past(vram_rd)); // R6

    AST_FIRST_PIXEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> (pix_x == '0)); // R3

endmodule

bind bitmap_line_fetch bmf_checker #(
    .XW     (XW),
    .YW     (YW),
    .LINE_W (LINE_W)
) u_bmf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .vram_rd   (vram_rd),
    .pal_rd    (pal_rd),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .line_done (line_done)
);

// File: tb/bitmap_line_fetch_test.sv
`timescale 1ns/1ps
module bitmap_line_fetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  line_num = '0;
    logic [15:0] ctrl_word = '0;
    logic [16:0] vram_addr;
    logic        vram_rd;
    logic [15:0] vram_data = '0;
    logic [8:0]  pal_addr;
    logic        pal_rd;
    logic [15:0] pal_data = '0;
    logic        pix_valid;
    logic [7:0]  pix_x;
    logic [7:0]  pix_y;
    logic [15:0] pix_color;
    logic        line_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bitmap_line_fetch uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .line_num  (line_num),
        .ctrl_word (ctrl_word),
        .vram_addr (vram_addr),
        .vram_rd   (vram_rd),
        .vram_data (vram_data),
        .pal_addr  (pal_addr),
        .pal_rd    (pal_rd),
        .pal_data  (pal_data),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .pix_color (pix_color),
        .line_done (line_done)
    );

    // Memory contents generated from the word-aligned byte offset
    function automatic logic [15:0] vfun(input logic [16:0] a);
        logic [31:0] p;
        p = {16'h0, a[16:1]} * 32'h9E37;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] pfun(input logic [8:0] a);
        return {a[8:1], ~a[8:1]} ^ 16'h0F0F;
    endfunction

    // Synchronous memory models, one cycle latency
    always_ff @(posedge clk) begin
        if (vram_rd) vram_data <= vfun(vram_addr);
        if (pal_rd)  pal_data  <= pfun(pal_addr);
    end

    // Expected color from the requirements (R4, R5, R6, R7)
    function automatic logic [15:0] exp_color(input logic [15:0] ctrl, input int ln, input int x);
        int a;
        logic [15:0] w;
        logic [7:0] b;
        if (ctrl[2:0] == 3'd3) begin
            return vfun(17'(2 * (ln * 240 + x)));
        end else if (ctrl[2:0] == 3'd4) begin
            a = (ctrl[4] ? 'hA000 : 0) + ln * 240 + x;
            w = vfun(17'(a & ~1));
            b = a[0] ? w[15:8] : w[7:0];
            return pfun({b, 1'b0});
        end
        return 16'h0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one line; optionally change ctrl or pulse start again mid-line
    task automatic run_line(input logic [15:0] ctrl, input logic [7:0] ln,
                            input bit do_alt, input bit do_restart);
        int npix = 0;
        int bad_pos = 0;
        int bad_col = 0;
        int done_cnt = 0;
        int done_at = -1;
        int reads = 0;
        int first_bad_act = 0;
        int first_bad_exp = 0;
        string req;
        @(negedge clk);
        ctrl_word = ctrl;
        line_num  = ln;
        start     = 1'b1;
        for (int c = 1; c <= 260; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (do_alt && c == 50) begin
                ctrl_word = ctrl ^ 16'h0017;
                line_num  = ln ^ 8'h01;
            end
            if (do_restart && c == 100) start = 1'b1;
            if (vram_rd || pal_rd) reads++;
            if (pix_valid) begin
                npix++;
                if (pix_x != 8'(c - 4) || pix_y != ln) bad_pos++;
                if (pix_color != exp_color(ctrl, ln, int'(pix_x))) begin
                    if (bad_col == 0) begin
                        first_bad_act = int'(pix_color);
                        first_bad_exp = int'(exp_color(ctrl, ln, int'(pix_x)));
                    end
                    bad_col++;
                end
            end
            if (line_done) begin
                done_cnt++;
                done_at = c;
                if (pix_x != 8'd239 || !pix_valid) done_at = -2;
            end
        end
        check(npix == 240, "R3 pixel count", npix, 240);
        check(bad_pos == 0, "R3 x/y timing", bad_pos, 0);
        req = (ctrl[2:0] == 3'd3) ? "R4 direct color" :
              (ctrl[2:0] == 3'd4) ? "R5 R6 indexed color" : "R7 zero color";
        check(bad_col == 0, req, first_bad_act, first_bad_exp);
        check(done_cnt == 1 && done_at == 243, "R8 done pulse", done_at, 243);
        if (ctrl[2:0] != 3'd3 && ctrl[2:0] != 3'd4)
            check(reads == 0, "R7 no memory reads", reads, 0);
        if (do_alt) check(bad_col == 0 && bad_pos == 0, "R2 held inputs", bad_col + bad_pos, 0);
        if (do_restart) check(npix == 240, "R9 restart ignored", npix, 240);
    endtask

    // Stimulus table: {ctrl_word, line_num}
    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        {16'h0003, 8'd0},
        {16'h0003, 8'd159},
        {16'h0004, 8'd5},
        {16'h0014, 8'd159},
        {16'h0013, 8'd77},
        {16'h0000, 8'd10},
        {16'h0017, 8'd3},
        {16'hFF04, 8'd100}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!pix_valid && !line_done && !vram_rd && !pal_rd, "R1 reset idle",
              {pix_valid, line_done, vram_rd, pal_rd}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!pix_valid && !vram_rd && !pal_rd, "R1 idle after reset",
              {pix_valid, vram_rd, pal_rd}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_line(VEC[i][23:8], VEC[i][7:0], 1'b0, 1'b0);
        end

        // R2: inputs changed mid-line
        run_line(16'h0014, 8'd20, 1'b1, 1'b0);
        run_line(16'h0003, 8'd66, 1'b1, 1'b0);
        // R9: start during fetch
        run_line(16'h0003, 8'd40, 1'b0, 1'b1);
        run_line(16'h0004, 8'd141, 1'b0, 1'b1);

        // R1: reset mid-line
        @(negedge clk);
        ctrl_word = 16'h0004;
        line_num  = 8'd9;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!pix_valid && !line_done && !vram_rd && !pal_rd, "R1 reset mid-line",
              {pix_valid, line_done, vram_rd, pal_rd}, 0);
        rst_n = 1'b1;
        begin
            int stray = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (pix_valid || vram_rd) stray++;
            end
            check(stray == 0, "R1 quiet after reset", stray, 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule